// File: doc/BRIEF.md
# Microcontroller Fault Pin Monitor

This block watches the fault signalling pins of a microcontroller and the error pin of an external companion IC. It turns the faults it sees into two requests for the rest of the safety logic: a fail-safe request, and a reset request. All three pins are asynchronous, so each one passes through a two-flop synchroniser before any level or edge is judged. The block has no register file. Configuration arrives as static inputs, and a one-cycle millisecond tick provides the time base.

The two microcontroller pins can be ignored, or only the first can be used. They can also be watched as two independent fault lines, each with its own active level. In the last mode they form a complementary bi-stable pair. In that mode, only one of the two complementary states means healthy, and that state is selected by configuration. Any other combination is a fault, including both pins at the same level.

The external error pin is armed by an edge of a chosen direction. The error is latched only if the pin stays at the new level for a chosen number of millisecond ticks. Once latched, the error stays set until a clear pulse is given.

Top module: `mcu_fault_monitor`

## Requirements
- R1: A change on a fault pin appears on the fault flags after the second rising clock edge, not after the first.
- R2: With `cfg_mode` = 0, both microcontroller fault flags stay low whatever the pins do.
- R3: With `cfg_mode` = 1, `mcu_flt_a` is high when pin A equals `cfg_pol_a` (1 = active-high, 0 = active-low), and `mcu_flt_b` stays low.
- R4: With `cfg_mode` = 2, `mcu_flt_a` follows R3, and `mcu_flt_b` is high when pin B equals `cfg_pol_b`.
- R5: With `cfg_mode` = 3, the healthy state is A = not `cfg_pair_pol` with B = `cfg_pair_pol`. Every other combination of A and B raises `mcu_flt_a`, and `mcu_flt_b` stays low.
- R6: `fs_req` is high whenever any fault flag is high. `rst_req` is high when a microcontroller flag is high and `cfg_mcu_rst` = 1, or when `ext_flt` is high and `cfg_ext_rst` = 1.
- R7: Only a transition of the external pin into the level given by `cfg_ext_edge` (1 = rising, 0 = falling) arms the acknowledge timer. Opposite transitions never arm it.
- R8: Once armed, `ext_flt` sets on the Nth `ms_tick` while the pin holds the active level. N is 1, 8, 16 or 32 for `cfg_ext_ack` codes 0 to 3. If the pin leaves the active level before that tick, the timer is cancelled.
- R9: `ext_flt` stays set until a `clr_ext` pulse clears it, and it stays set after the pin returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| flt_a_pin | input | 1 | Microcontroller fault pin A (asynchronous) |
| flt_b_pin | input | 1 | Microcontroller fault pin B (asynchronous) |
| ext_err_pin | input | 1 | External IC error pin (asynchronous) |
| cfg_mode | input | 2 | 0 off, 1 A only, 2 independent, 3 bi-stable pair |
| cfg_pol_a | input | 1 | Active level of pin A in modes 1 and 2 |
| cfg_pol_b | input | 1 | Active level of pin B in mode 2 |
| cfg_pair_pol | input | 1 | Level of pin B in the healthy pair state |
| cfg_mcu_rst | input | 1 | Microcontroller faults also request reset |
| cfg_ext_edge | input | 1 | Arming edge of the external pin: 1 rising, 0 falling |
| cfg_ext_ack | input | 2 | Acknowledge time code: 1, 8, 16 or 32 ticks |
| cfg_ext_rst | input | 1 | External error also requests reset |
| clr_ext | input | 1 | Write-one clear of the external error flag |
| mcu_flt_a | output | 1 | Fault flag for pin A, or for the pair |
| mcu_flt_b | output | 1 | Fault flag for pin B |
| ext_flt | output | 1 | Latched external error flag |
| fs_req | output | 1 | Fail-safe request |
| rst_req | output | 1 | Reset request |

## Verification
The microcontroller path is swept over every combination of mode, the three polarity inputs, the two pin levels and the reset impact bit. This separates the single-input, independent and pair decodes from one another, and it shows that equal pin levels in pair mode count as faults. For each edge direction and each acknowledge code, the external path is run three ways. A held pulse is counted to one tick short of its limit and then to the limit. A pulse is released early and then followed by extra ticks. An edge of the wrong direction is given. Together these tell apart off-by-one tick counts, cancellation, edge selection and the stickiness of the flag.

// File: rtl/mcu_fault_monitor.sv
module mcu_fault_monitor #(
  parameter int ACK_T0 = 1,
  parameter int ACK_T1 = 8,
  parameter int ACK_T2 = 16,
  parameter int ACK_T3 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       flt_a_pin,
  input  logic       flt_b_pin,
  input  logic       ext_err_pin,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_pol_a,
  input  logic       cfg_pol_b,
  input  logic       cfg_pair_pol,
  input  logic       cfg_mcu_rst,
  input  logic       cfg_ext_edge,
  input  logic [1:0] cfg_ext_ack,
  input  logic       cfg_ext_rst,
  input  logic       clr_ext,
  output logic       mcu_flt_a,
  output logic       mcu_flt_b,
  output logic       ext_flt,
  output logic       fs_req,
  output logic       rst_req
);
  localparam int CW = $clog2(ACK_T3 + 1);

  logic [2:0]    sync1, sync2;
  logic          ext_d, pend;
  logic [CW-1:0] cnt, lim;
  logic          a_s, b_s, e_s, pair_ok, arm, held, ext_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      ext_d <= 1'b0;
    end else begin
      sync1 <= {ext_err_pin, flt_b_pin, flt_a_pin};
      sync2 <= sync1;
      ext_d <= sync2[2];
    end

  assign a_s = sync2[0];
  assign b_s = sync2[1];
  assign e_s = sync2[2];

  assign pair_ok = (a_s == ~cfg_pair_pol) && (b_s == cfg_pair_pol);

  always_comb begin
    mcu_flt_a = 1'b0;
    mcu_flt_b = 1'b0;
    case (cfg_mode)
      2'd1: mcu_flt_a = (a_s == cfg_pol_a);
      2'd2: begin
        mcu_flt_a = (a_s == cfg_pol_a);
        mcu_flt_b = (b_s == cfg_pol_b);
      end
      2'd3: mcu_flt_a = ~pair_ok;
      default: ;
    endcase
  end

  always_comb
    case (cfg_ext_ack)
      2'd0:    lim = CW'(ACK_T0);
      2'd1:    lim = CW'(ACK_T1);
      2'd2:    lim = CW'(ACK_T2);
      default: lim = CW'(ACK_T3);
    endcase

  assign arm     = (e_s != ext_d) && (e_s == cfg_ext_edge);
  assign held    = (e_s == cfg_ext_edge);
  assign ext_set = pend && held && ms_tick && ((cnt + 1'b1) == lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend    <= 1'b0;
      cnt     <= '0;
      ext_flt <= 1'b0;
    end else begin
      if (arm) begin
        pend <= 1'b1;
        cnt  <= '0;
      end else if (pend && !held) begin
        pend <= 1'b0;
      end else if (ext_set) begin
        pend <= 1'b0;
      end else if (pend && ms_tick) begin
        cnt <= cnt + 1'b1;
      end
      if (ext_set)      ext_flt <= 1'b1;
      else if (clr_ext) ext_flt <= 1'b0;
    end

  assign fs_req  = mcu_flt_a | mcu_flt_b | ext_flt;
  assign rst_req = ((mcu_flt_a | mcu_flt_b) & cfg_mcu_rst) | (ext_flt & cfg_ext_rst);

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == 2'd0 |-> !mcu_flt_a && !mcu_flt_b); // R2
  AST_PAIR_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == 2'd3 |-> !mcu_flt_b); // R5
  AST_RST_NEEDS_FS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> fs_req); // R6
  AST_EXT_SET_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flt) |-> $past(pend) && $past(ms_tick)); // R8
  AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_flt && !clr_ext |=> ext_flt); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> cnt < lim); // R8
endmodule

// File: tb/mcu_fault_monitor_tb_top.sv
module mcu_fault_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 0, fa = 0, fb = 0, fe = 0;
  logic [1:0] mode = 0, ack = 0;
  logic pa = 0, pb = 0, pp = 0, mrst = 0, edg = 1, erst = 0, clr = 0;
  logic oa, ob, oe, ofs, orst;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mcu_fault_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .flt_a_pin(fa), .flt_b_pin(fb), .ext_err_pin(fe),
    .cfg_mode(mode), .cfg_pol_a(pa), .cfg_pol_b(pb), .cfg_pair_pol(pp),
    .cfg_mcu_rst(mrst), .cfg_ext_edge(edg), .cfg_ext_ack(ack),
    .cfg_ext_rst(erst), .clr_ext(clr),
    .mcu_flt_a(oa), .mcu_flt_b(ob), .ext_flt(oe), .fs_req(ofs), .rst_req(orst));

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (a,b,e,fs,rst)", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic clear_ext();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    cyc_n(1);
  endtask

  function automatic logic [4:0] exp_vec(input logic e);
    logic ea, eb;
    ea = 0; eb = 0;
    case (mode)
      2'd1: ea = (fa == pa);
      2'd2: begin ea = (fa == pa); eb = (fb == pb); end
      2'd3: ea = !((fa == !pp) && (fb == pp));
      default: ;
    endcase
    return {ea, eb, e, ea | eb | e, ((ea | eb) & mrst) | (e & erst)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lims[4];
    lims = '{1, 8, 16, 32};
    cyc_n(3);
    chk("R6 reset", {oa, ob, oe, ofs, orst}, 5'b0);
    @(negedge clk) rst_n = 1'b1;
    cyc_n(2);

    // R1: two-edge latency, mode 1 active-high
    mode = 2'd1; pa = 1'b1; fa = 1'b0;
    cyc_n(3);
    @(negedge clk) fa = 1'b1;
    @(negedge clk);
    chk("R1 first edge", {4'b0, oa}, 5'b0);
    @(negedge clk);
    chk("R1 second edge", {4'b0, oa}, 5'b1);

    // R2..R6 exhaustive sweep
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < 64; v++) begin
        @(negedge clk);
        mode = m[1:0];
        {pa, pb, pp, fa, fb, mrst} = v[5:0];
        cyc_n(3);
        case (m)
          0: chk("R2 off", {oa, ob, oe, ofs, orst}, exp_vec(1'b0));
          1: chk("R3 single", {oa, ob, oe, ofs, orst}, exp_vec(1'b0));
          2: chk("R4 indep", {oa, ob, oe, ofs, orst}, exp_vec(1'b0));
          default: chk("R5 pair R6", {oa, ob, oe, ofs, orst}, exp_vec(1'b0));
        endcase
      end

    // external path
    @(negedge clk) mode = 2'd0; mrst = 0;
    for (int ed = 0; ed < 2; ed++)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        edg = ed[0]; ack = k[1:0]; erst = k[0];
        fe = !edg;
        cyc_n(4);
        clear_ext();
        @(negedge clk) fe = edg;
        cyc_n(4);
        tick(lims[k] - 1);
        cyc_n(2);
        chk("R8 one short", {2'b0, oe, ofs, orst}, 5'b0);
        tick(1);
        cyc_n(2);
        chk("R8 at limit R6", {2'b0, oe, ofs, orst}, {2'b0, 1'b1, 1'b1, erst});
        @(negedge clk) fe = !edg;
        cyc_n(4);
        tick(3);
        chk("R9 sticky", {4'b0, oe}, 5'b1);
        clear_ext();
        chk("R9 cleared", {4'b0, oe}, 5'b0);
        @(negedge clk) fe = edg;
        cyc_n(4);
        tick(lims[k] - 1);
        @(negedge clk) fe = !edg;
        cyc_n(4);
        tick(lims[k] + 1);
        cyc_n(2);
        chk("R8 cancelled", {4'b0, oe}, 5'b0);
        // wrong edge: transition into the non-selected level
        @(negedge clk) fe = edg;
        cyc_n(4);
        tick(lims[k] + 1);
        @(negedge clk) fe = !edg;
        cyc_n(4);
        clear_ext();
        tick(lims[k] + 1);
        cyc_n(2);
        chk("R7 wrong edge", {4'b0, oe}, 5'b0);
      end

    // R7: edge seen while a different direction was selected does not arm
    @(negedge clk) edg = 1'b0; ack = 2'd0; fe = 1'b0;
    cyc_n(4);
    clear_ext();
    @(negedge clk) fe = 1'b1;
    cyc_n(4);
    @(negedge clk) edg = 1'b1;
    tick(3);
    cyc_n(2);
    chk("R7 unarmed", {4'b0, oe}, 5'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule